// File: doc/BRIEF.md
# Expanded-Memory Page Window Translator

This block turns a CPU address from a 286/386-class system into a physical DRAM address. The low megabyte holds 32 windows of 16 KB each. Any window can be pointed at a 16 KB page anywhere in DRAM through one of 64 page mapping registers. The registers form two banks of 32, and the active bank is picked by a context-select input. The physical page is built from a page number, a bank number and, depending on the configured bank size and the chip revision, some extra high bits.

Accesses that do not go through a window follow fixed rules:
- The top 128 KB of the first megabyte passes through unchanged.
- Its alias just below 16 MB is folded back into the first megabyte.
- Other addresses at or above 1 MB may be moved down by 384 KB so that the RAM hidden behind the video and ROM area is reclaimed.

A write port, driven by a separate register-decode block, loads the mapping registers. Each translation is registered and appears one cycle after the request, together with a flag showing that a window translated it and a miss flag showing that the result lies beyond installed memory.

Top module: `ems_xlate`

## Requirements
- R1: After reset, out_valid, ems_hit and dram_miss are low. A request accepted on one rising edge produces out_valid high, with its result, on the next rising edge and on that edge only.
- R2: There are two window ranges, and only addresses with bits 23:20 equal to zero fall in them.
  - 040000h-09FFFFh holds slots 0 to 23 in 16 KB steps.
  - 0C0000h-0DFFFFh holds slots 24 to 31.
  - A slot uses mapping register index {context, slot}.
  - A translated address keeps CPU bits 13:0, and mapping register bits 4:0 become physical bits 18:14.
- R3: A window translates only when mapping register bit 9 is set and cfg_ems_en is high. An untranslated window access leaves the address unchanged and reports ems_hit low.
- R4: cfg_ctx selects which group of 32 registers serves the windows. Indices 0-31 serve context 0 and indices 32-63 serve context 1.
- R5: Mapping register bits 8:7 select bank 0 to 3.
  - Bank bases are laid out back to back from address 0, and each bank is 2^shift bytes.
  - The shift is 21 when cfg_big_bank is high and 19 otherwise.
  - The bank base is added to the in-bank address.
- R6: When the selected bank's shift is 21 or more, mapping register bits 6:5 are merged into physical bits 20:19. With shift 19 they have no effect.
- R7: When cfg_rev equals 8, cfg_huge_bank is high and cfg_big_bank is low, the shift is 23, and mapping register bits 11:10 are merged into physical bits 22:21. In every other case cfg_huge_bank and bits 11:10 have no effect.
- R8: When cfg_rev is 1 to 7 and cfg_alt_bank is high, banks 2 and 3 use the other shift: 21 if the base shift is 19, and 19 if it is 21. On revision 0 or 8, cfg_alt_bank has no effect.
- R9: Two ranges bypass translation and report ems_hit low.
  - Addresses 0E0000h-0FFFFFh pass through unchanged.
  - Addresses FE0000h-FFFFFFh are reduced to their low 20 bits.
- R10: A non-window address at or above 100000h has 60000h subtracted when cfg_no_reloc is low and MEM_KB is at least 1024. Otherwise it is unchanged.
- R11: dram_miss is high exactly when the produced physical address is at or above MEM_KB×1024 bytes.
- R12: A mapping register written on one rising edge is used by a request accepted on any later edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| map_we | input | 1 | Mapping register write strobe |
| map_idx | input | 6 | Mapping register index {context, slot} |
| map_data | input | 12 | Mapping register write value |
| cfg_ems_en | input | 1 | Global window translation enable |
| cfg_ctx | input | 1 | Active register context |
| cfg_big_bank | input | 1 | Selects 2^21-byte banks |
| cfg_huge_bank | input | 1 | Selects 2^23-byte banks on revision 8 |
| cfg_alt_bank | input | 1 | Banks 2 and 3 use the other shift (revisions 1-7) |
| cfg_no_reloc | input | 1 | Disables the 384 KB downward move above 1 MB |
| cfg_rev | input | 4 | Chip revision code |
| req_valid | input | 1 | Translation request |
| cpu_addr | input | ADDR_W | CPU address |
| out_valid | output | 1 | Result valid |
| phys_addr | output | PHYS_W | Physical DRAM address |
| ems_hit | output | 1 | Result came from a window translation |
| dram_miss | output | 1 | Result lies beyond installed memory |

## Verification
The bench builds two instances with the default address widths. The first has MEM_KB = 4096, where relocation is active and 4 MB forms a miss boundary that both relocated and bank-translated addresses can cross. The second has MEM_KB = 512, so relocation is switched off by the memory size and a plain 1.4 MB address must miss. Running the same requests through both separates the size-dependent rules from the configuration-dependent ones. Hand-computed addresses cover all bank shifts, including the revision-8 23-bit banks and the mixed shifts of alternate banks.

// File: rtl/ems_pkg.sv
package ems_pkg;

  localparam int MAP_W   = 12;
  localparam int SLOT_W  = 5;
  localparam int IDX_W   = SLOT_W + 1;
  localparam int PAGE_SH = 14;
  localparam int SH_W    = 5;

  localparam logic [SH_W-1:0] SH_SMALL = 5'd19;
  localparam logic [SH_W-1:0] SH_BIG   = 5'd21;
  localparam logic [SH_W-1:0] SH_HUGE  = 5'd23;
  localparam logic [3:0]      REV_WIDE = 4'd8;

  typedef struct packed {
    logic [1:0] extra;
    logic       en;
    logic [1:0] bank;
    logic [1:0] hi;
    logic [4:0] page;
  } map_t;

  typedef enum logic [1:0] {
    REG_PASS,
    REG_FOLD,
    REG_WIN,
    REG_OTHER
  } region_e;

endpackage

// File: rtl/ems_map_ram.sv
module ems_map_ram
  import ems_pkg::*;
#(
  parameter int DEPTH = 1 << IDX_W,
  parameter int WIDTH = MAP_W
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] wr_idx,
  input  logic [WIDTH-1:0]         wr_data,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic [WIDTH-1:0]         rd_data
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wr_idx] <= wr_data;
  end

  assign rd_data = mem[rd_idx];

endmodule

// File: rtl/ems_window_decode.sv
module ems_window_decode
  import ems_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic [ADDR_W-1:PAGE_SH] blk_addr,
  output region_e                 region,
  output logic [SLOT_W-1:0]       slot
);

  localparam int LO_FIRST = 16;
  localparam int LO_LAST  = 39;
  localparam int HI_FIRST = 48;
  localparam int HI_LAST  = 55;
  localparam int HI_BIAS  = 24;

  logic [5:0] blk;
  logic       first_mb;
  logic       in_lo;
  logic       in_hi;
  logic       in_top;
  logic [5:0] slot_full;

  always_comb begin
    blk      = blk_addr[19:PAGE_SH];
    first_mb = (blk_addr[ADDR_W-1:20] == '0);
    in_lo    = first_mb && (int'(blk) >= LO_FIRST) && (int'(blk) <= LO_LAST);
    in_hi    = first_mb && (int'(blk) >= HI_FIRST) && (int'(blk) <= HI_LAST);
    in_top   = &blk_addr[ADDR_W-1:17];

    if (first_mb && (blk_addr[19:17] == 3'b111))
      region = REG_PASS;
    else if (in_top)
      region = REG_FOLD;
    else if (in_lo || in_hi)
      region = REG_WIN;
    else
      region = REG_OTHER;

    slot_full = in_hi ? (blk - 6'(HI_BIAS)) : (blk - 6'(LO_FIRST));
    slot      = slot_full[SLOT_W-1:0];
  end

endmodule

// File: rtl/ems_bank_calc.sv
module ems_bank_calc
  import ems_pkg::*;
#(
  parameter int PHYS_W = 25
) (
  input  logic              cfg_big_bank,
  input  logic              cfg_huge_bank,
  input  logic              cfg_alt_bank,
  input  logic [3:0]        cfg_rev,
  input  logic [1:0]        bank,
  output logic [SH_W-1:0]   sel_shift,
  output logic [PHYS_W-1:0] bank_base
);

  localparam int NBANK = 4;
  localparam int EXT_W = PHYS_W + 1;

  logic            wide_rev;
  logic            alt_on;
  logic [SH_W-1:0] sh_lo;
  logic [SH_W-1:0] sh_hi;
  logic [EXT_W-1:0] unit_lo;
  logic [EXT_W-1:0] unit_hi;
  logic [EXT_W-1:0] bases [NBANK];

  always_comb begin
    wide_rev = (cfg_rev == REV_WIDE);
    alt_on   = cfg_alt_bank && (cfg_rev != 4'd0) && (cfg_rev < REV_WIDE);
    if (cfg_big_bank)
      sh_lo = SH_BIG;
    else if (wide_rev && cfg_huge_bank)
      sh_lo = SH_HUGE;
    else
      sh_lo = SH_SMALL;
    if (alt_on)
      sh_hi = cfg_big_bank ? SH_SMALL : SH_BIG;
    else
      sh_hi = sh_lo;
    unit_lo = EXT_W'(1) << sh_lo;
    unit_hi = EXT_W'(1) << sh_hi;
  end

  genvar b;
  generate
    for (b = 0; b < NBANK; b++) begin : g_base
      if (b < 2) begin : g_low
        assign bases[b] = unit_lo * EXT_W'(b);
      end else begin : g_upper
        assign bases[b] = (unit_lo << 1) + unit_hi * EXT_W'(b - 2);
      end
    end
  endgenerate

  always_comb begin
    sel_shift = bank[1] ? sh_hi : sh_lo;
    bank_base = bases[bank][PHYS_W-1:0];
  end

endmodule

// File: rtl/ems_xlate.sv
module ems_xlate
  import ems_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int PHYS_W = 25,
  parameter int MEM_KB = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              map_we,
  input  logic [IDX_W-1:0]  map_idx,
  input  logic [MAP_W-1:0]  map_data,
  input  logic              cfg_ems_en,
  input  logic              cfg_ctx,
  input  logic              cfg_big_bank,
  input  logic              cfg_huge_bank,
  input  logic              cfg_alt_bank,
  input  logic              cfg_no_reloc,
  input  logic [3:0]        cfg_rev,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              out_valid,
  output logic [PHYS_W-1:0] phys_addr,
  output logic              ems_hit,
  output logic              dram_miss
);

  localparam longint unsigned MEM_BYTES = longint'(MEM_KB) * 64'd1024;
  localparam bit              RELOC_OK  = (MEM_KB >= 1024);
  localparam logic [PHYS_W-1:0] ONE_MB  = PHYS_W'(32'h100000);
  localparam logic [PHYS_W-1:0] HOLE    = PHYS_W'(32'h060000);

  region_e          region;
  logic [SLOT_W-1:0] slot;
  logic [MAP_W-1:0] map_raw;
  map_t             map;
  logic [SH_W-1:0]  sel_shift;
  logic [PHYS_W-1:0] bank_base;
  logic [PHYS_W-1:0] addr_ext;
  logic [PHYS_W-1:0] in_bank;
  logic [PHYS_W-1:0] pa_next;
  logic              use_ems;
  logic              miss_next;

  ems_map_ram #(.DEPTH(1 << IDX_W), .WIDTH(MAP_W)) u_map (
    .clk     (clk),
    .we      (map_we),
    .wr_idx  (map_idx),
    .wr_data (map_data),
    .rd_idx  ({cfg_ctx, slot}),
    .rd_data (map_raw)
  );

  ems_window_decode #(.ADDR_W(ADDR_W)) u_dec (
    .blk_addr (cpu_addr[ADDR_W-1:PAGE_SH]),
    .region   (region),
    .slot     (slot)
  );

  assign map = map_t'(map_raw);

  ems_bank_calc #(.PHYS_W(PHYS_W)) u_bank (
    .cfg_big_bank  (cfg_big_bank),
    .cfg_huge_bank (cfg_huge_bank),
    .cfg_alt_bank  (cfg_alt_bank),
    .cfg_rev       (cfg_rev),
    .bank          (map.bank),
    .sel_shift     (sel_shift),
    .bank_base     (bank_base)
  );

  always_comb begin
    addr_ext = PHYS_W'(cpu_addr);
    use_ems  = (region == REG_WIN) && cfg_ems_en && map.en;

    in_bank = PHYS_W'({map.page, cpu_addr[PAGE_SH-1:0]});
    if (sel_shift >= SH_BIG)
      in_bank = in_bank | (PHYS_W'(map.hi) << 19);
    if ((cfg_rev == REV_WIDE) && (sel_shift == SH_HUGE))
      in_bank = in_bank | (PHYS_W'(map.extra) << 21);

    unique case (region)
      REG_PASS: pa_next = addr_ext;
      REG_FOLD: pa_next = PHYS_W'(cpu_addr[19:0]);
      default: begin
        if (use_ems)
          pa_next = in_bank + bank_base;
        else if (RELOC_OK && !cfg_no_reloc && (addr_ext >= ONE_MB))
          pa_next = addr_ext - HOLE;
        else
          pa_next = addr_ext;
      end
    endcase

    miss_next = (64'(pa_next) >= MEM_BYTES);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      phys_addr <= '0;
      ems_hit   <= 1'b0;
      dram_miss <= 1'b0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        phys_addr <= pa_next;
        ems_hit   <= use_ems;
        dram_miss <= miss_next;
      end
    end
  end

endmodule

// File: rtl/ems_xlate_chk.sv
module ems_xlate_chk #(
  parameter int ADDR_W = 24,
  parameter int PHYS_W = 25,
  parameter int MEM_KB = 4096
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_ems_en,
  input logic              req_valid,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              out_valid,
  input logic [PHYS_W-1:0] phys_addr,
  input logic              ems_hit,
  input logic              dram_miss
);

  localparam longint unsigned LIMIT = longint'(MEM_KB) * 64'd1024;

  logic pass_rng;
  logic fold_rng;
  assign pass_rng = (cpu_addr[ADDR_W-1:20] == '0) && (cpu_addr[19:17] == 3'b111);
  assign fold_rng = &cpu_addr[ADDR_W-1:17];

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_valid);

  assert_idle_follows_R1: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !out_valid);

  assert_offset_kept_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (!ems_hit || (phys_addr[13:0] == $past(cpu_addr[13:0]))));

  assert_hit_needs_enable_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !cfg_ems_en) |=> !ems_hit);

  assert_pass_through_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && pass_rng) |=> (!ems_hit && (phys_addr == PHYS_W'($past(cpu_addr)))));

  assert_fold_low_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && fold_rng) |=> (!ems_hit && (phys_addr == PHYS_W'($past(cpu_addr[19:0])))));

  assert_in_range_R11: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !dram_miss) |-> (64'(phys_addr) < LIMIT));

  assert_miss_range_R11: assert property (@(posedge clk) disable iff (rst)
    (out_valid && dram_miss) |-> (64'(phys_addr) >= LIMIT));

endmodule

bind ems_xlate ems_xlate_chk #(
  .ADDR_W (ADDR_W),
  .PHYS_W (PHYS_W),
  .MEM_KB (MEM_KB)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_ems_en (cfg_ems_en),
  .req_valid  (req_valid),
  .cpu_addr   (cpu_addr),
  .out_valid  (out_valid),
  .phys_addr  (phys_addr),
  .ems_hit    (ems_hit),
  .dram_miss  (dram_miss)
);

// File: tb/ems_xlate_tb.sv
`timescale 1ns/1ps
module ems_xlate_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        map_we = 1'b0;
  logic [5:0]  map_idx = '0;
  logic [11:0] map_data = '0;
  logic        cfg_ems_en = 1'b0;
  logic        cfg_ctx = 1'b0;
  logic        cfg_big_bank = 1'b0;
  logic        cfg_huge_bank = 1'b0;
  logic        cfg_alt_bank = 1'b0;
  logic        cfg_no_reloc = 1'b0;
  logic [3:0]  cfg_rev = 4'd0;
  logic        req_valid = 1'b0;
  logic [23:0] cpu_addr = '0;

  logic        ov_a, hit_a, miss_a;
  logic [24:0] pa_a;
  logic        ov_b, hit_b, miss_b;
  logic [24:0] pa_b;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ems_xlate #(.MEM_KB(4096)) u_dut (
    .clk(clk), .rst(rst), .map_we(map_we), .map_idx(map_idx), .map_data(map_data),
    .cfg_ems_en(cfg_ems_en), .cfg_ctx(cfg_ctx), .cfg_big_bank(cfg_big_bank),
    .cfg_huge_bank(cfg_huge_bank), .cfg_alt_bank(cfg_alt_bank),
    .cfg_no_reloc(cfg_no_reloc), .cfg_rev(cfg_rev), .req_valid(req_valid),
    .cpu_addr(cpu_addr), .out_valid(ov_a), .phys_addr(pa_a), .ems_hit(hit_a),
    .dram_miss(miss_a)
  );

  ems_xlate #(.MEM_KB(512)) u_dut_small (
    .clk(clk), .rst(rst), .map_we(map_we), .map_idx(map_idx), .map_data(map_data),
    .cfg_ems_en(cfg_ems_en), .cfg_ctx(cfg_ctx), .cfg_big_bank(cfg_big_bank),
    .cfg_huge_bank(cfg_huge_bank), .cfg_alt_bank(cfg_alt_bank),
    .cfg_no_reloc(cfg_no_reloc), .cfg_rev(cfg_rev), .req_valid(req_valid),
    .cpu_addr(cpu_addr), .out_valid(ov_b), .phys_addr(pa_b), .ems_hit(hit_b),
    .dram_miss(miss_b)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_map(input logic [5:0] idx, input logic [11:0] val);
    @(negedge clk);
    map_we = 1'b1; map_idx = idx; map_data = val;
    @(negedge clk);
    map_we = 1'b0;
  endtask

  task automatic set_cfg(input logic en, input logic ctx, input logic big,
                         input logic huge, input logic alt, input logic [3:0] rev);
    cfg_ems_en = en; cfg_ctx = ctx; cfg_big_bank = big;
    cfg_huge_bank = huge; cfg_alt_bank = alt; cfg_rev = rev;
  endtask

  // Issue one request; results of both instances appear at the next rising edge.
  task automatic issue(input logic [23:0] a);
    @(negedge clk);
    req_valid = 1'b1; cpu_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic probe(input string req, input logic [23:0] a,
                       input logic [24:0] exp_pa, input logic exp_hit, input logic exp_miss);
    issue(a);
    check({req, " valid"}, 32'(ov_a), 32'd1);
    check({req, " addr"}, 32'(pa_a), 32'(exp_pa));
    check({req, " hit"}, 32'(hit_a), 32'(exp_hit));
    check({req, " miss"}, 32'(miss_a), 32'(exp_miss));
  endtask

  task automatic t_reset();
    check("R1 reset valid", 32'(ov_a), 32'd0);
    check("R1 reset hit", 32'(hit_a), 32'd0);
    check("R1 reset miss", 32'(miss_a), 32'd0);
    @(negedge clk);
    check("R1 idle valid", 32'(ov_a), 32'd0);
  endtask

  task automatic t_bypass();
    set_cfg(1, 0, 0, 0, 0, 4'd0);
    probe("R9 pass E0000", 24'h0E1234, 25'h0E1234, 0, 0);
    probe("R9 pass FFFFF", 24'h0FFFFF, 25'h0FFFFF, 0, 0);
    probe("R9 fold FE", 24'hFE5678, 25'h0E5678, 0, 0);
    probe("R9 fold FF", 24'hFFFFFF, 25'h0FFFFF, 0, 0);
  endtask

  task automatic t_reloc();
    cfg_no_reloc = 1'b0;
    probe("R10 reloc", 24'h160000, 25'h100000, 0, 0);
    probe("R10 reloc 1MB", 24'h100000, 25'h0A0000, 0, 0);
    probe("R10 below 1MB", 24'h0A0000, 25'h0A0000, 0, 0);
    issue(24'h160000);
    check("R10 small mem no reloc", 32'(pa_b), 32'h160000);
    check("R11 small mem miss", 32'(miss_b), 32'd1);
    cfg_no_reloc = 1'b1;
    probe("R10 reloc off", 24'h160000, 25'h160000, 0, 0);
    cfg_no_reloc = 1'b0;
  endtask

  task automatic t_basic();
    set_cfg(1, 0, 0, 0, 0, 4'd0);
    wr_map(6'd0, 12'h205);
    wr_map(6'd1, 12'h303);
    wr_map(6'd2, 12'h39F);
    probe("R2 page bank0", 24'h041234, 25'h015234, 1, 0);
    issue(24'h041234);
    check("R11 small mem hit in range", 32'(miss_b), 32'd0);
    probe("R5 bank2 shift19", 24'h044010, 25'h10C010, 1, 0);
    probe("R5 bank3 shift19", 24'h04BFFF, 25'h1FFFFF, 1, 0);
    wr_map(6'd24, 12'h201);
    wr_map(6'd31, 12'h202);
    probe("R2 slot24", 24'h0C0004, 25'h004004, 1, 0);
    probe("R2 slot31", 24'h0DC008, 25'h008008, 1, 0);
  endtask

  task automatic t_context();
    wr_map(6'd32, 12'h207);
    wr_map(6'd33, 12'h000);
    set_cfg(1, 0, 0, 0, 0, 4'd0);
    probe("R4 ctx0", 24'h040000, 25'h014000, 1, 0);
    set_cfg(1, 1, 0, 0, 0, 4'd0);
    probe("R4 ctx1", 24'h040000, 25'h01C000, 1, 0);
    probe("R3 entry off", 24'h044010, 25'h044010, 0, 0);
    set_cfg(0, 0, 0, 0, 0, 4'd0);
    probe("R3 global off", 24'h041234, 25'h041234, 0, 0);
  endtask

  task automatic t_big();
    wr_map(6'd0, 12'h2E5);
    set_cfg(1, 0, 1, 0, 0, 4'd0);
    probe("R6 shift21 high bits", 24'h041234, 25'h395234, 1, 0);
    set_cfg(1, 0, 0, 0, 0, 4'd0);
    probe("R6 shift19 high ignored", 24'h041234, 25'h095234, 1, 0);
  endtask

  task automatic t_huge();
    wr_map(6'd3, 12'hAA2);
    set_cfg(1, 0, 0, 1, 0, 4'd8);
    probe("R7 rev8 shift23", 24'h04C100, 25'hC88100, 1, 1);
    set_cfg(1, 0, 1, 1, 0, 4'd8);
    probe("R7 rev8 big wins", 24'h04C100, 25'h288100, 1, 0);
    set_cfg(1, 0, 0, 1, 0, 4'd0);
    probe("R7 rev0 huge ignored", 24'h04C100, 25'h088100, 1, 0);
  endtask

  task automatic t_alt();
    set_cfg(1, 0, 0, 0, 1, 4'd2);
    probe("R8 alt bank3 to 21", 24'h04BFFF, 25'h37FFFF, 1, 0);
    probe("R8 alt bank2", 24'h044010, 25'h10C010, 1, 0);
    set_cfg(1, 0, 1, 0, 1, 4'd2);
    probe("R8 alt bank3 to 19", 24'h04BFFF, 25'h4FFFFF, 1, 1);
    set_cfg(1, 0, 0, 0, 1, 4'd8);
    probe("R8 rev8 alt ignored", 24'h04BFFF, 25'h1FFFFF, 1, 0);
    set_cfg(1, 0, 0, 0, 1, 4'd0);
    probe("R8 rev0 alt ignored", 24'h04BFFF, 25'h1FFFFF, 1, 0);
  endtask

  task automatic t_boundary();
    set_cfg(1, 0, 0, 0, 0, 4'd0);
    probe("R11 just below", 24'h45FFFF, 25'h3FFFFF, 0, 0);
    probe("R11 at limit", 24'h460000, 25'h400000, 0, 1);
  endtask

  task automatic t_rewrite();
    set_cfg(1, 0, 0, 0, 0, 4'd0);
    wr_map(6'd5, 12'h209);
    probe("R12 first write", 24'h054000, 25'h024000, 1, 0);
    wr_map(6'd5, 12'h20A);
    probe("R12 rewrite", 24'h054000, 25'h028000, 1, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    for (int i = 0; i < 64; i++) wr_map(6'(i), 12'h000);
    t_bypass();
    t_reloc();
    t_basic();
    t_context();
    t_big();
    t_huge();
    t_alt();
    t_boundary();
    t_rewrite();
    summary();
    $finish;
  end

endmodule